// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 32-bit timer channel driven over a small synchronous register bus. An up-counter advances by one on every clock where the tick enable input is high and the channel is running. When a tick arrives while the count equals the programmed terminal count, the channel records a match event. The count returns to zero and a pending flag is set. In continuous mode the channel keeps running, so events repeat every terminal-count-plus-one ticks. In one-shot mode the channel stops after the first event and waits for a new enable command.

Software controls the channel with three command offsets (clear, start, stop). Any write to one of these acts as the command, whatever the data. Further registers hold the mode bit, the interrupt-enable bit, an acknowledge register and the terminal count. A read-only status word and the live count can be read back. The interrupt output is the pending flag gated by the interrupt enable. Read data is registered and appears on the bus one cycle after the read strobe.

Top module: `mmio_interval_timer`

## Requirements
- R1: After reset the count reads 0, the terminal count reads 0xFFFFFFFF, the status word reads 0x01 and irqOut is low.
- R2: The word offsets are 0x00 clear, 0x04 start, 0x08 stop, 0x0C mode, 0x10 status, 0x14 count and 0x18 terminal count. The interrupt-enable register is at 0x1C and acknowledge is at 0x20. The terminal count reads back what was written. Writes to the count offset 0x14 are ignored.
- R3: A write of any data to 0x04 starts the channel. While running, each clock with tickEn high raises the count by one. Status bits [3:0] read 2 (active) and bit 4 reads 1.
- R4: A write to 0x08 stops the channel. The count then holds through further ticks, and status bits [3:0] read 1 (idle) with bit 4 clear.
- R5: In continuous mode (mode bit 0 = 0), a tick that arrives while count equals the terminal count sets the pending flag (status bit 7) and returns the count to 0. The channel keeps running and the event repeats every terminal-count-plus-one ticks.
- R6: In one-shot mode (mode bit 0 = 1, shown in status bit 5), the match event sets pending, returns the count to 0 and stops the channel (state code 1). The count stays at 0 until another start command.
- R7: A write to 0x20 with data bit 7 set clears the pending flag. A write there with bit 7 clear has no effect.
- R8: A write to 0x00 clears the count and the pending flag. It leaves the terminal count, mode, interrupt enable and run state unchanged.
- R9: irqOut is high exactly when pending is set and interrupt-enable bit 0 (at 0x1C, shown in status bit 6) is 1. Pending stays set while the interrupt is disabled.
- R10: Reads of the write-only offsets (0x00, 0x04, 0x08, 0x0C, 0x1C, 0x20) and of unmapped offsets return 0. Read data is valid on the clock after the read strobe.
- R11: A match event and an acknowledge in the same cycle leave the pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable pulse |
| regAddr | input | ADDR_W (8) | Register byte offset |
| regWrite | input | 1 | Write strobe |
| regWdata | input | DATA_W (32) | Write data |
| regRead | input | 1 | Read strobe |
| regRdata | output | DATA_W (32) | Read data, registered |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench counts ticks one at a time to hit the match exactly at the terminal count. A counter that fires one tick early or late, or that fails to wrap to zero, shows up as a wrong count or pending bit. One-shot mode is checked with extra ticks after the event; a design that keeps counting would read a nonzero count. The same-cycle acknowledge and match case is driven directly; a design that gives the acknowledge priority would lose the event. Command writes carry nonzero and odd data, the bit-7-clear acknowledge is tried, and writes go to the read-only count. These catch decoders that look at data or address the wrong register.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // Register byte offsets (software visible, fixed)
  localparam int OFS_CLEAR  = 'h00;
  localparam int OFS_START  = 'h04;
  localparam int OFS_STOP   = 'h08;
  localparam int OFS_MODE   = 'h0C;
  localparam int OFS_STATUS = 'h10;
  localparam int OFS_COUNT  = 'h14;
  localparam int OFS_TERM   = 'h18;
  localparam int OFS_IRQEN  = 'h1C;
  localparam int OFS_ACK    = 'h20;

  // Status word layout
  localparam int ST_CODE_W   = 4;
  localparam int ST_IDLE     = 1;
  localparam int ST_ACTIVE   = 2;
  localparam int ST_RUN_BIT  = 4;
  localparam int ST_MODE_BIT = 5;
  localparam int ST_IE_BIT   = 6;
  localparam int ST_PEND_BIT = 7;

  // Control-to-datapath strobes
  typedef struct packed {
    logic cntClear;
    logic cntAdvance;
    logic termLoad;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_datapath.sv
`timescale 1ns/1ps
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmr_strobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] termVal,
  output logic              hitEvt
);
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] termQ;

  // Match happens on an advancing tick that finds count at terminal
  assign hitEvt = strb.cntAdvance && !strb.cntClear && (countQ == termQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      termQ  <= '1;
    end else begin
      if (strb.termLoad) termQ <= wrData;
      if (strb.cntClear)        countQ <= '0;
      else if (hitEvt)          countQ <= '0;
      else if (strb.cntAdvance) countQ <= countQ + 1'b1;
    end
  end

  assign countVal = countQ;
  assign termVal  = termQ;
endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic              wrBit0,
  input  logic              wrBit7,
  input  logic              regRead,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] termVal,
  input  logic              hitEvt,
  output tmr_strobe_t       strb,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic              runQ,
  output logic              oneShotQ,
  output logic              irqEnQ,
  output logic              pendQ
);
  logic wrClear, wrStart, wrStop, wrMode, wrTerm, wrIrqEn, wrAck;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] rdMux;

  assign wrClear = regWrite && (regAddr == ADDR_W'(OFS_CLEAR));
  assign wrStart = regWrite && (regAddr == ADDR_W'(OFS_START));
  assign wrStop  = regWrite && (regAddr == ADDR_W'(OFS_STOP));
  assign wrMode  = regWrite && (regAddr == ADDR_W'(OFS_MODE));
  assign wrTerm  = regWrite && (regAddr == ADDR_W'(OFS_TERM));
  assign wrIrqEn = regWrite && (regAddr == ADDR_W'(OFS_IRQEN));
  assign wrAck   = regWrite && (regAddr == ADDR_W'(OFS_ACK)) && wrBit7;

  always_comb begin
    strb            = '0;
    strb.cntClear   = wrClear;
    strb.cntAdvance = runQ && tickEn;
    strb.termLoad   = wrTerm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      oneShotQ <= 1'b0;
      irqEnQ   <= 1'b0;
      pendQ    <= 1'b0;
    end else begin
      if (hitEvt && oneShotQ) runQ <= 1'b0;
      if (wrStop)             runQ <= 1'b0;
      if (wrStart)            runQ <= 1'b1;
      if (wrMode)  oneShotQ <= wrBit0;
      if (wrIrqEn) irqEnQ   <= wrBit0;
      // clear command wins, then a match, then an acknowledge
      if (wrClear)     pendQ <= 1'b0;
      else if (hitEvt) pendQ <= 1'b1;
      else if (wrAck)  pendQ <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[ST_CODE_W-1:0] = runQ ? ST_CODE_W'(ST_ACTIVE) : ST_CODE_W'(ST_IDLE);
    statusWord[ST_RUN_BIT]    = runQ;
    statusWord[ST_MODE_BIT]   = oneShotQ;
    statusWord[ST_IE_BIT]     = irqEnQ;
    statusWord[ST_PEND_BIT]   = pendQ;
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(OFS_STATUS): rdMux = statusWord;
      ADDR_W'(OFS_COUNT):  rdMux = countVal;
      ADDR_W'(OFS_TERM):   rdMux = termVal;
      default:             rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        regRdata <= '0;
    else if (regRead) regRdata <= rdMux;
    else              regRdata <= '0;
  end

  assign irqOut = pendQ && irqEnQ;
endmodule

// File: rtl/mmio_interval_timer.sv
`timescale 1ns/1ps
module mmio_interval_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regRead,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  tmr_strobe_t       strb;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] termVal;
  logic              hitEvt;
  logic              runQ, oneShotQ, irqEnQ, pendQ;

  tmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .regAddr  (regAddr),
    .regWrite (regWrite),
    .wrBit0   (regWdata[0]),
    .wrBit7   (regWdata[ST_PEND_BIT]),
    .regRead  (regRead),
    .countVal (countVal),
    .termVal  (termVal),
    .hitEvt   (hitEvt),
    .strb     (strb),
    .regRdata (regRdata),
    .irqOut   (irqOut),
    .runQ     (runQ),
    .oneShotQ (oneShotQ),
    .irqEnQ   (irqEnQ),
    .pendQ    (pendQ)
  );

  tmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWdata),
    .countVal (countVal),
    .termVal  (termVal),
    .hitEvt   (hitEvt)
  );
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrite,
  input logic              ackBit,
  input tmr_strobe_t       strb,
  input logic              hitEvt,
  input logic [DATA_W-1:0] countVal,
  input logic              runQ,
  input logic              oneShotQ,
  input logic              irqEnQ,
  input logic              pendQ,
  input logic              irqOut
);
  logic ackWr, startWr;
  assign ackWr   = regWrite && (regAddr == ADDR_W'(OFS_ACK)) && ackBit;
  assign startWr = regWrite && (regAddr == ADDR_W'(OFS_START));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntAdvance && !hitEvt && !strb.cntClear |=> countVal == $past(countVal) + 1'b1);

  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntAdvance && !strb.cntClear |=> $stable(countVal));

  p_wrap_pend_r5: assert property (@(posedge clk) disable iff (!rstN)
    hitEvt |=> countVal == '0 && pendQ);

  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    hitEvt && oneShotQ && !startWr |=> !runQ);

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ackWr && !hitEvt |=> !pendQ);

  p_clear_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClear |=> countVal == '0 && !pendQ);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> pendQ && irqEnQ);

  p_hit_beats_ack_r11: assert property (@(posedge clk) disable iff (!rstN)
    hitEvt && ackWr |=> pendQ);
endmodule

bind mmio_interval_timer tmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrite (regWrite),
  .ackBit   (regWdata[7]),
  .strb     (strb),
  .hitEvt   (hitEvt),
  .countVal (countVal),
  .runQ     (runQ),
  .oneShotQ (oneShotQ),
  .irqEnQ   (irqEnQ),
  .pendQ    (pendQ),
  .irqOut   (irqOut)
);

// File: tb/tb_mmio_interval_timer.sv
`timescale 1ns/1ps
module tb_mmio_interval_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrite = 1'b0;
  logic [31:0] regWdata = '0;
  logic        regRead = 1'b0;
  logic [31:0] regRdata;
  logic        irqOut;

  int nChecks = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  mmio_interval_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr),
    .regWrite(regWrite), .regWdata(regWdata), .regRead(regRead),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRead = 1'b1;
    @(negedge clk);
    d = regRdata; regRead = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic test_reset_state();
    logic [31:0] d;
    rd(8'h14, d); chk("R1 count", d, 32'h0);
    rd(8'h18, d); chk("R1 term", d, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R1 status", d, 32'h01);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic test_term_rw();
    logic [31:0] d;
    wr(8'h18, 32'h5); rd(8'h18, d); chk("R2 term readback", d, 32'h5);
  endtask

  task automatic test_start_stop();
    logic [31:0] d;
    wr(8'h04, 32'h0);
    tick(3);
    rd(8'h14, d); chk("R3 count after 3 ticks", d, 32'h3);
    rd(8'h10, d); chk("R3 status active", d, 32'h12);
    wr(8'h08, 32'h0);
    tick(2);
    rd(8'h14, d); chk("R4 count held", d, 32'h3);
    rd(8'h10, d); chk("R4 status idle", d, 32'h01);
  endtask

  task automatic test_continuous();
    logic [31:0] d;
    wr(8'h00, 32'h0);
    wr(8'h18, 32'h4);
    wr(8'h0C, 32'h0);
    wr(8'h1C, 32'h1);
    wr(8'h04, 32'hDEAD_BEEF);
    tick(4);
    rd(8'h14, d); chk("R5 count at terminal", d, 32'h4);
    rd(8'h10, d); chk("R5 no pending yet", d, 32'h52);
    tick(1);
    rd(8'h14, d); chk("R5 wrapped to zero", d, 32'h0);
    rd(8'h10, d); chk("R5 status pending", d, 32'hD2);
    chk("R5 irq high", {31'b0, irqOut}, 32'h1);
    wr(8'h20, 32'h7F);
    rd(8'h10, d); chk("R7 ack without bit7 ignored", d, 32'hD2);
    wr(8'h20, 32'h80);
    rd(8'h10, d); chk("R7 ack clears pending", d, 32'h52);
    chk("R7 irq low", {31'b0, irqOut}, 32'h0);
    tick(5);
    rd(8'h10, d); chk("R5 second event", d, 32'hD2);
    rd(8'h14, d); chk("R5 second wrap", d, 32'h0);
  endtask

  task automatic test_oneshot();
    logic [31:0] d;
    wr(8'h08, 32'h0);
    tick(2);
    wr(8'h00, 32'h1234);
    rd(8'h14, d); chk("R8 count cleared", d, 32'h0);
    rd(8'h10, d); chk("R8 pending cleared, ie kept", d, 32'h41);
    rd(8'h18, d); chk("R8 term kept", d, 32'h4);
    wr(8'h0C, 32'h1);
    wr(8'h04, 32'h0);
    tick(5);
    rd(8'h10, d); chk("R6 one-shot event idle", d, 32'hE1);
    rd(8'h14, d); chk("R6 count zero", d, 32'h0);
    tick(3);
    rd(8'h14, d); chk("R6 stays stopped", d, 32'h0);
    wr(8'h04, 32'h0);
    tick(2);
    rd(8'h14, d); chk("R6 restart counts", d, 32'h2);
    rd(8'h10, d); chk("R6 running one-shot", d, 32'hF2);
  endtask

  task automatic test_irq_gate();
    logic [31:0] d;
    wr(8'h1C, 32'h0);
    chk("R9 irq masked", {31'b0, irqOut}, 32'h0);
    rd(8'h10, d); chk("R9 pending kept while masked", d & 32'hC0, 32'h80);
    wr(8'h1C, 32'h1);
    chk("R9 irq unmasked", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic test_reads_and_ro();
    logic [31:0] d;
    logic [7:0] offs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h1C, 8'h20, 8'h24, 8'h40};
    for (int i = 0; i < 8; i++) begin
      rd(offs[i], d); chk("R10 write-only/unmapped reads zero", d, 32'h0);
    end
    wr(8'h14, 32'h1234);
    rd(8'h14, d); chk("R2 count ignores writes", d, 32'h2);
  endtask

  task automatic test_hit_with_ack();
    logic [31:0] d;
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h0);
    wr(8'h18, 32'h2);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    tick(2);
    @(negedge clk);
    regAddr = 8'h20; regWdata = 32'h80; regWrite = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    regWrite = 1'b0; tickEn = 1'b0; regWdata = '0;
    rd(8'h10, d); chk("R11 pending survives same-cycle ack", d & 32'h80, 32'h80);
    rd(8'h14, d); chk("R11 count wrapped", d, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset_state();
    test_term_rw();
    test_start_stop();
    test_continuous();
    test_oneshot();
    test_irq_gate();
    test_reads_and_ro();
    test_hit_with_ack();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule